// File: doc/BRIEF.md
# Reloadable DMA Transfer Counter

This block holds the byte count for a host-programmed DMA transfer. The host writes a 24-bit start count, one byte per write, into three count locations. Those writes only update a start-count holding register. The working counter is loaded from it when the host writes a command byte whose DMA flag is set. A start count of zero loads as 65536. The working counter then counts down by one for each byte accepted on the pseudo-DMA byte stream. When it reaches zero it raises a terminal-count flag. An external completion pulse can also end the transfer: it forces the count to zero and raises the flag.

The host reads the working counter back through a combinational read port at the same three locations. The high location is an exception. Until the host has written it once after reset, it returns a fixed identification byte instead of the count, so software can probe for the block. The pseudo-DMA stream uses valid/ready signalling. The block never applies back-pressure: `pd_ready` is always high, and every byte with `pd_valid` high is accepted in that cycle. A byte accepted while the count is already zero is dropped and leaves the counter at zero. Data buffering and interrupt generation belong to neighbouring blocks.

Top module: `xfer_count_top`

## Requirements
- R1: After reset the working count is 0, `tc` is 0 and `dma_mode` is 0. A read of location 2 returns `CHIP_ID` (default 8'hA2), and reads of locations 0, 1 and 3 return 0.
- R2: A host write to location 0, 1 or 2 stores the byte into start-count bits [7:0], [15:8] or [23:16] respectively. It does not change the working count that reads return.
- R3: A host write to location 3 with bit 7 set loads the working count from the start count. A start count of zero loads 0x010000 instead. The loaded value is visible on reads in the cycle after the write.
- R4: A host write to location 3 sets `dma_mode` to bit 7 of the written byte. When bit 7 is 0, the working count is not changed.
- R5: A host write to location 0, 1 or 2 clears `tc` in the next cycle, unless a terminal event (R8, R9) occurs in the same cycle.
- R6: Reads of location 2 return `CHIP_ID` until location 2 has been written once. After that they return bits [23:16] of the working count. A reset makes `CHIP_ID` visible again.
- R7: Each cycle with `pd_valid` high decrements a nonzero working count by one. A byte accepted when the count is 0 is discarded and the count stays 0. `pd_ready` is always 1.
- R8: `tc` becomes 1 in the cycle after a byte decrements the count from 1 to 0.
- R9: A `xfer_done` pulse forces the working count to 0 and sets `tc` in the next cycle.
- R10: When events coincide, the working count obeys a fixed priority: `xfer_done` first, then a DMA command load, then a byte decrement. A terminal event sets `tc` even when a count write in the same cycle would clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | AW (2) | Write location: 0..2 start-count bytes, 3 command |
| host_wdata | input | 8 | Write data; bit 7 is the DMA flag for command writes |
| rd_addr | input | AW (2) | Read location |
| rd_data | output | 8 | Read data for `rd_addr` (combinational) |
| pd_valid | input | 1 | A pseudo-DMA byte is offered |
| pd_ready | output | 1 | Byte acceptance, tied high |
| xfer_done | input | 1 | Transfer-complete pulse |
| dma_mode | output | 1 | DMA mode set by the last command write |
| tc | output | 1 | Terminal-count status flag |

## Verification
Two things can fall in the same cycle. A count-register write can coincide with the byte that takes the count from 1 to 0, where a clear meets a set. A DMA command load or a completion pulse can coincide with a byte decrement. The bench forces each of these pairs in directed cycles. It also produces them at random by mixing frequent small start counts with dense byte traffic. A bench model applies the stated priority, and its count and `tc` are compared with the port readback every cycle.

// File: rtl/xfer_cnt_pkg.sv
`timescale 1ns/1ps
package xfer_cnt_pkg;

  // Operation selected for the working counter in one cycle
  typedef enum logic [1:0] {
    CNT_HOLD  = 2'd0,
    CNT_DEC   = 2'd1,
    CNT_LOAD  = 2'd2,
    CNT_CLEAR = 2'd3
  } cnt_op_e;

endpackage

// File: rtl/xfer_start_regs.sv
`timescale 1ns/1ps
module xfer_start_regs #(
  parameter int NB     = 3,
  parameter int BYTE_W = 8,
  parameter int AW     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [BYTE_W-1:0]    data_i,
  output logic [NB*BYTE_W-1:0] start_o,
  output logic                 hi_written_o
);

  localparam logic [AW-1:0] HI_ADDR = AW'(NB - 1);

  // One holding byte per count location
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              byte_q <= '0;
      else if (wr_i && addr_i == AW'(g))       byte_q <= data_i;
    end
    assign start_o[g*BYTE_W +: BYTE_W] = byte_q;
  end

  // Sticky flag: the high location has been written since reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          hi_written_o <= 1'b0;
    else if (wr_i && addr_i == HI_ADDR)  hi_written_o <= 1'b1;
  end

  assert_hi_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == HI_ADDR) |=> hi_written_o);

  assert_hi_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hi_written_o |=> hi_written_o);

endmodule

// File: rtl/xfer_counter.sv
`timescale 1ns/1ps
module xfer_counter
  import xfer_cnt_pkg::*;
#(
  parameter int          CNT_W     = 24,
  parameter int unsigned ZERO_LOAD = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] start_i,
  input  logic             dec_i,
  input  logic             done_i,
  input  logic             clr_tc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tc_o
);

  localparam logic [CNT_W-1:0] RELOAD_Z = CNT_W'(ZERO_LOAD);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  cnt_op_e          op;
  logic             hit_zero;
  logic [CNT_W-1:0] load_val;

  // Priority: completion, then command load, then byte decrement
  always_comb begin
    if (done_i)                         op = CNT_CLEAR;
    else if (load_i)                    op = CNT_LOAD;
    else if (dec_i && cnt_o != '0)      op = CNT_DEC;
    else                                op = CNT_HOLD;
  end

  assign hit_zero = (op == CNT_DEC) && (cnt_o == ONE);
  assign load_val = (start_i == '0) ? RELOAD_Z : start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else begin
      case (op)
        CNT_CLEAR: cnt_o <= '0;
        CNT_LOAD:  cnt_o <= load_val;
        CNT_DEC:   cnt_o <= cnt_o - ONE;
        default:   cnt_o <= cnt_o;
      endcase
    end
  end

  // Terminal events win over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tc_o <= 1'b0;
    else if (done_i || hit_zero)   tc_o <= 1'b1;
    else if (clr_tc_i)             tc_o <= 1'b0;
  end

  assert_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && !done_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - ONE);

  assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && !done_i && cnt_o == '0) |=> cnt_o == '0);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !done_i) |=> cnt_o == (($past(start_i) == '0) ? RELOAD_Z : $past(start_i)));

  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (cnt_o == '0) && tc_o);

  assert_tc_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_o) |-> ($past(done_i) || ($past(dec_i) && !$past(load_i) && $past(cnt_o) == ONE)));

  assert_tc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tc_i && !done_i && !(dec_i && !load_i && cnt_o == ONE)) |=> !tc_o);

endmodule

// File: rtl/xfer_rd_mux.sv
`timescale 1ns/1ps
module xfer_rd_mux #(
  parameter int              NB      = 3,
  parameter int              BYTE_W  = 8,
  parameter int              AW      = 2,
  parameter logic [BYTE_W-1:0] CHIP_ID = 8'hA2
) (
  input  logic [AW-1:0]        rd_addr_i,
  input  logic [NB*BYTE_W-1:0] cnt_i,
  input  logic                 hi_written_i,
  output logic [BYTE_W-1:0]    rd_data_o
);

  localparam logic [AW-1:0] HI_ADDR = AW'(NB - 1);

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (rd_addr_i == AW'(i)) rd_data_o = cnt_i[i*BYTE_W +: BYTE_W];
    end
    if (rd_addr_i == HI_ADDR && !hi_written_i) rd_data_o = CHIP_ID;
  end

  always_comb begin
    if (rd_addr_i == HI_ADDR && !hi_written_i)
      assert_id_R6: assert (rd_data_o == CHIP_ID);
  end

endmodule

// File: rtl/xfer_count_top.sv
`timescale 1ns/1ps
module xfer_count_top #(
  parameter int          CNT_W     = 24,
  parameter int          BYTE_W    = 8,
  parameter int          DMA_BIT   = 7,
  parameter int unsigned ZERO_LOAD = 65536,
  parameter logic [7:0]  CHIP_ID   = 8'hA2,
  localparam int         NB        = CNT_W / BYTE_W,
  localparam int         AW        = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [AW-1:0]     host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              pd_valid,
  output logic              pd_ready,
  input  logic              xfer_done,
  output logic              dma_mode,
  output logic              tc
);

  localparam logic [AW-1:0] CMD_ADDR = AW'(NB);

  logic             cnt_wr;
  logic             cmd_wr;
  logic             load;
  logic [CNT_W-1:0] start;
  logic [CNT_W-1:0] cnt;
  logic             hi_written;

  assign cnt_wr   = host_wr && (host_addr < CMD_ADDR);
  assign cmd_wr   = host_wr && (host_addr == CMD_ADDR);
  assign load     = cmd_wr && host_wdata[DMA_BIT];
  assign pd_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dma_mode <= 1'b0;
    else if (cmd_wr) dma_mode <= host_wdata[DMA_BIT];
  end

  xfer_start_regs #(.NB(NB), .BYTE_W(BYTE_W), .AW(AW)) u_start (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (cnt_wr),
    .addr_i       (host_addr),
    .data_i       (host_wdata),
    .start_o      (start),
    .hi_written_o (hi_written)
  );

  xfer_counter #(.CNT_W(CNT_W), .ZERO_LOAD(ZERO_LOAD)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .start_i  (start),
    .dec_i    (pd_valid && pd_ready),
    .done_i   (xfer_done),
    .clr_tc_i (cnt_wr),
    .cnt_o    (cnt),
    .tc_o     (tc)
  );

  xfer_rd_mux #(.NB(NB), .BYTE_W(BYTE_W), .AW(AW), .CHIP_ID(CHIP_ID)) u_rd (
    .rd_addr_i    (rd_addr),
    .cnt_i        (cnt),
    .hi_written_i (hi_written),
    .rd_data_o    (rd_data)
  );

  assert_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> dma_mode == $past(host_wdata[DMA_BIT]));

  assert_nomode_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !host_wdata[DMA_BIT] && !xfer_done && !pd_valid) |=> $stable(cnt));

  assert_cntwr_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !xfer_done && !pd_valid) |=> $stable(cnt));

endmodule

// File: tb/sim_xfer_count_top.sv
`timescale 1ns/1ps
module sim_xfer_count_top;

  localparam logic [7:0] CHIP = 8'hA2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       pd_valid = 1'b0;
  logic       pd_ready;
  logic       xfer_done = 1'b0;
  logic       dma_mode;
  logic       tc;

  int n_run = 0;
  int n_fail = 0;

  int unsigned mcnt;
  bit          mtc, mdma, mhi;
  bit [7:0]    mstart [3];

  always #2.5 clk = ~clk;

  xfer_count_top u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .pd_valid(pd_valid), .pd_ready(pd_ready), .xfer_done(xfer_done),
    .dma_mode(dma_mode), .tc(tc)
  );

  function automatic logic [7:0] exp_rd(int a);
    if (a == 2 && !mhi) return CHIP;
    if (a < 3) return 8'((mcnt >> (8 * a)) & 32'hff);
    return 8'h00;
  endfunction

  task automatic check(string tag, string what, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  // Compare all outputs with the model; called after a clock edge
  task automatic check_all(string tag);
    check(tag, "tc", int'(tc), int'(mtc));
    check(tag, "dma_mode", int'(dma_mode), int'(mdma));
    check(tag, "pd_ready", int'(pd_ready), 1);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #0.2;
      check(tag, $sformatf("rd[%0d]", a), int'(rd_data), int'(exp_rd(a)));
    end
  endtask

  task automatic model(bit wr, int addr, int data, bit pd, bit dn);
    bit          load;
    bit          setev;
    int unsigned st;
    load  = wr && addr == 3 && data[7];
    st    = {8'h00, mstart[2], mstart[1], mstart[0]};
    setev = dn || (!load && pd && mcnt == 1);
    if (dn)                     mcnt = 0;
    else if (load)              mcnt = (st == 0) ? 32'h10000 : st;
    else if (pd && mcnt != 0)   mcnt = mcnt - 1;
    if (setev)                  mtc = 1'b1;
    else if (wr && addr < 3)    mtc = 1'b0;
    if (wr && addr == 3)        mdma = data[7];
    if (wr && addr < 3)         mstart[addr] = 8'(data);
    if (wr && addr == 2)        mhi = 1'b1;
  endtask

  task automatic step(string tag, bit wr, int addr, int data, bit pd, bit dn);
    @(negedge clk);
    host_wr = wr; host_addr = 2'(addr); host_wdata = 8'(data);
    pd_valid = pd; xfer_done = dn;
    @(posedge clk);
    model(wr, addr, data, pd, dn);
    #0.5;
    host_wr = 1'b0; pd_valid = 1'b0; xfer_done = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    host_wr = 1'b0; pd_valid = 1'b0; xfer_done = 1'b0;
    mcnt = 0; mtc = 0; mdma = 0; mhi = 0;
    for (int i = 0; i < 3; i++) mstart[i] = 8'h00;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    do_reset();
    check_all("R1");

    // Start-count writes do not touch the working count
    step("R2", 1, 0, 3, 0, 0);
    step("R2", 1, 1, 0, 0, 0);
    check(("R6"), "hi before write", int'(exp_rd(2)), int'(CHIP));

    // DMA command load
    step("R3", 1, 3, 8'h80, 0, 0);
    check("R3", "loaded", int'(mcnt), 3);

    // Count down to zero, terminal count, then discard at zero
    step("R7", 0, 0, 0, 1, 0);
    step("R7", 0, 0, 0, 1, 0);
    step("R8", 0, 0, 0, 1, 0);
    check("R8", "tc model", int'(mtc), 1);
    step("R7", 0, 0, 0, 1, 0);

    // Count write clears tc
    step("R5", 1, 1, 0, 0, 0);

    // Non-DMA command leaves counter alone
    step("R4", 1, 0, 5, 0, 0);
    step("R4", 1, 3, 8'h10, 0, 0);

    // Zero start count loads 65536; high location still shows ID
    step("R3", 1, 0, 0, 0, 0);
    step("R3", 1, 3, 8'h81, 0, 0);
    check("R3", "zero reload", int'(mcnt), 32'h10000);
    step("R6", 1, 2, 0, 0, 0);
    step("R6", 1, 3, 8'h80, 0, 0);

    // Completion pulse
    step("R9", 0, 0, 0, 1, 1);

    // Collisions
    step("R10", 1, 2, 0, 0, 0);
    step("R10", 1, 0, 1, 0, 0);
    step("R10", 1, 3, 8'h80, 0, 0);
    step("R10", 1, 1, 0, 1, 0);      // clear meets 1->0 decrement
    step("R10", 1, 0, 9, 0, 0);
    step("R10", 1, 3, 8'h80, 1, 0);  // load beats decrement
    step("R10", 1, 3, 8'h80, 1, 1);  // done beats load

    // Reset brings the ID back
    do_reset();
    check_all("R6");

    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      bit wr, pd, dn;
      int addr, data;
      wr   = ($urandom % 5) == 0;
      pd   = ($urandom % 2) == 0;
      dn   = ($urandom % 40) == 0;
      addr = int'($urandom % 4);
      if (addr == 3) data = (($urandom % 5) < 3) ? int'(8'h80 | ($urandom % 128)) : int'($urandom % 128);
      else           data = (($urandom % 4) == 0) ? int'($urandom % 256) : int'($urandom % 3);
      step("R10", wr, addr, data, pd, dn);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule